// File: doc/BRIEF.md
# Tamper-Erased Backup Register File

This block holds a small set of user data words in the always-powered backup domain. Software reads and writes the words through a simple indexed port. A tamper pin, watched by a synchronizer and detector, wipes every word to zero the moment an attack is seen. It also sets a sticky flag, which can raise an interrupt.

Two resets reach the block. The system reset only returns the tamper logic and flag to idle and blocks writes while it is held; the stored words come through it unchanged. The backup-domain reset is the only reset that clears the words. The detector works either on the rising transition of the pin or on its high level.

Top module: `tamper_bkp_regfile`

## Requirements
- R1: The block stores twenty 32-bit words at indices 0 to 19. A write presented at a rising clock edge is visible on `rdata` (a combinational read of `addr`) from that edge on.
- R2: Indices 20 to 31 read as zero, and writes to them change no stored word.
- R3: While `bkp_rst_n` is low, every stored word and the tamper flag are zero.
- R4: Asserting `sys_rst_n` low leaves every stored word unchanged and ignores writes while it is held. It clears the tamper flag.
- R5: `tamper_in` passes through two synchronizing flip-flops. A change driven before clock edge N takes effect (erase and flag) at edge N+2.
- R6: With `tamp_en` = 0, no tamper event occurs whatever `tamper_in` does.
- R7: With `tamp_level` = 0 (edge mode), only a low-to-high transition of the synchronized input is an event. Holding the pin high produces a single event.
- R8: With `tamp_level` = 1 (level mode), every cycle in which the synchronized input is high is an event. Words stay erased while the pin is high.
- R9: A tamper event clears all twenty words to zero.
- R10: A tamper event sets `tamp_flag`. The flag stays at 1 until a cycle with `flag_clr` = 1, and an event in the same cycle as a clear leaves it at 1.
- R11: `tamp_irq` is 1 exactly when `tamp_flag` = 1 and `irq_en` = 1.
- R12: A write in the same cycle as an erase is lost; the word reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | System reset, active low; keeps stored words |
| bkp_rst_n | input | 1 | Backup-domain reset, active low; clears words |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 5 | Word index for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Word at `addr`, zero for indices above 19 |
| tamper_in | input | 1 | Asynchronous tamper pin, active high |
| tamp_en | input | 1 | Tamper detection enable |
| tamp_level | input | 1 | 0 = rising-edge detection, 1 = high-level detection |
| irq_en | input | 1 | Tamper interrupt enable |
| flag_clr | input | 1 | Clears the tamper flag (software writing 0) |
| tamp_flag | output | 1 | Sticky tamper flag |
| tamp_irq | output | 1 | Tamper interrupt |

## Verification
Reads cost no cycles: `rdata` follows `addr` inside the same cycle, and a write is readable just after the edge that takes it. A tamper change needs two edges to cross the synchronizer, and the erase and flag land on the third edge. The flag clear and the interrupt follow within one edge or none. The bench drives every input on the falling edge and samples one falling edge after each edge that should act. For the tamper path it checks before the acting edge (contents intact, flag 0) and after it (contents zero, flag 1), so a result that is one cycle early or late is caught.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  typedef struct packed {
    logic enable;
    logic level_mode;
  } tamp_cfg_t;

  function automatic logic idx_in_range(input int unsigned idx, input int unsigned n_words);
    return idx < n_words;
  endfunction

  function automatic logic event_rule(input logic en, input logic level_mode,
                                      input logic cur, input logic prev);
    if (!en) return 1'b0;
    if (level_mode) return cur;
    return cur & ~prev;
  endfunction

endpackage

// File: rtl/tbr_detect.sv
module tbr_detect
  import tbr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tamper_raw,
  input  tamp_cfg_t cfg,
  output logic      tamper_evt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= tamper_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign tamper_evt = event_rule(cfg.enable, cfg.level_mode,
                                 sync_q[SYNC_STAGES-1], prev_q);

endmodule

// File: rtl/tbr_flag.sv
module tbr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en,
  output logic flag_o,
  output logic irq_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  assign irq_o = flag_o & irq_en;

endmodule

// File: rtl/tbr_store.sv
module tbr_store
  import tbr_pkg::*;
#(
  parameter int NUM_WORDS = 20,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5
) (
  input  logic                        clk,
  input  logic                        bkp_rst_n,
  input  logic                        wr_ok,
  input  logic                        erase,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic [NUM_WORDS*DATA_W-1:0] flat
);

  genvar w;
  generate
    for (w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      logic              hit;
      assign hit = wr_ok && (int'(addr) == w);
      always_ff @(posedge clk or negedge bkp_rst_n) begin
        if (!bkp_rst_n)  word_q <= '0;
        else if (erase)  word_q <= '0;
        else if (hit)    word_q <= wdata;
      end
      assign flat[w*DATA_W +: DATA_W] = word_q;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (idx_in_range(int'(addr), NUM_WORDS))
      rdata = flat[int'(addr)*DATA_W +: DATA_W];
  end

endmodule

// File: rtl/tamper_bkp_regfile.sv
module tamper_bkp_regfile
  import tbr_pkg::*;
#(
  parameter int NUM_WORDS   = 20,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              bkp_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tamper_in,
  input  logic              tamp_en,
  input  logic              tamp_level,
  input  logic              irq_en,
  input  logic              flag_clr,
  output logic              tamp_flag,
  output logic              tamp_irq
);

  logic                        any_rst_n;
  logic                        tamper_evt;
  logic                        wr_ok;
  logic [NUM_WORDS*DATA_W-1:0] store_flat;
  tamp_cfg_t                   cfg;

  assign any_rst_n = sys_rst_n & bkp_rst_n;
  assign cfg       = '{enable: tamp_en, level_mode: tamp_level};
  assign wr_ok     = wr_en & sys_rst_n & idx_in_range(int'(addr), NUM_WORDS);

  tbr_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk        (clk),
    .rst_n      (any_rst_n),
    .tamper_raw (tamper_in),
    .cfg        (cfg),
    .tamper_evt (tamper_evt)
  );

  tbr_flag u_flag (
    .clk    (clk),
    .rst_n  (any_rst_n),
    .set_i  (tamper_evt),
    .clr_i  (flag_clr),
    .irq_en (irq_en),
    .flag_o (tamp_flag),
    .irq_o  (tamp_irq)
  );

  tbr_store #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk       (clk),
    .bkp_rst_n (bkp_rst_n),
    .wr_ok     (wr_ok),
    .erase     (tamper_evt),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .flat      (store_flat)
  );

endmodule

// File: rtl/tbr_checker.sv
module tbr_checker #(
  parameter int NUM_WORDS = 20,
  parameter int DATA_W    = 32,
  localparam int ADDR_W   = $clog2(NUM_WORDS)
) (
  input logic                        clk,
  input logic                        sys_rst_n,
  input logic                        bkp_rst_n,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [DATA_W-1:0]           wdata,
  input logic [DATA_W-1:0]           rdata,
  input logic                        tamp_en,
  input logic                        irq_en,
  input logic                        flag_clr,
  input logic                        tamp_flag,
  input logic                        tamp_irq,
  input logic                        tamper_evt,
  input logic [NUM_WORDS*DATA_W-1:0] store_flat
);

  logic              wr_hit_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  always_ff @(posedge clk or negedge bkp_rst_n) begin
    if (!bkp_rst_n) begin
      wr_hit_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_hit_q  <= wr_en && sys_rst_n && !tamper_evt && (int'(addr) < NUM_WORDS);
      wr_addr_q <= addr;
      wr_data_q <= wdata;
    end
  end

  // R1
  write_lands_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    wr_hit_q |-> (store_flat[int'(wr_addr_q)*DATA_W +: DATA_W] == wr_data_q));

  // R2
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    (int'(addr) >= NUM_WORDS) |-> (rdata == '0));

  // R4
  sysrst_keeps_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    !sys_rst_n |=> $stable(store_flat));

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n || !sys_rst_n)
    !tamp_en |-> !tamper_evt);

  // R9
  erase_all_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n || !sys_rst_n)
    tamper_evt |=> (store_flat == '0));

  // R10
  flag_sets_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n || !sys_rst_n)
    tamper_evt |=> tamp_flag);

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n || !sys_rst_n)
    (tamp_flag && !flag_clr) |=> tamp_flag);

  // R11
  irq_gated_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n || !sys_rst_n)
    tamp_irq |-> (tamp_flag && irq_en));

endmodule

bind tamper_bkp_regfile tbr_checker #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .sys_rst_n  (sys_rst_n),
  .bkp_rst_n  (bkp_rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .tamp_en    (tamp_en),
  .irq_en     (irq_en),
  .flag_clr   (flag_clr),
  .tamp_flag  (tamp_flag),
  .tamp_irq   (tamp_irq),
  .tamper_evt (tamper_evt),
  .store_flat (store_flat)
);

// File: tb/tamper_bkp_regfile_tb.sv
module tamper_bkp_regfile_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 20;

  logic        clk = 1'b0;
  logic        sys_rst_n, bkp_rst_n, wr_en, tamper_in, tamp_en, tamp_level, irq_en, flag_clr;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic        tamp_flag, tamp_irq;

  int          n_vec = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  logic [31:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  tamper_bkp_regfile dut_i (
    .clk(clk), .sys_rst_n(sys_rst_n), .bkp_rst_n(bkp_rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tamper_in(tamper_in),
    .tamp_en(tamp_en), .tamp_level(tamp_level), .irq_en(irq_en),
    .flag_clr(flag_clr), .tamp_flag(tamp_flag), .tamp_irq(tamp_irq)
  );

  function automatic logic [31:0] pat(input int i, input int seed);
    return (32'h9E3779B9 * (i + 1)) ^ (32'h01010101 * seed) ^ 32'(i);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    wr_en = 1'b1; addr = 5'(idx); wdata = d;
    tick();
    wr_en = 1'b0;
    if (idx < NW) model[idx] = d;
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 32; i++) begin
      addr = 5'(i); #1;
      check(req, rdata, (i < NW) ? model[i] : 32'h0);
    end
  endtask

  task automatic zero_model();
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < NW; i++) wr(i, pat(i, seed));
  endtask

  initial begin
    sys_rst_n = 0; bkp_rst_n = 0; wr_en = 0; addr = 0; wdata = 0;
    tamper_in = 0; tamp_en = 0; tamp_level = 0; irq_en = 0; flag_clr = 0;
    zero_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R3: reset state
    read_all("R3");
    check("R3 flag", 32'(tamp_flag), 0);
    check("R11 irq", 32'(tamp_irq), 0);
    sys_rst_n = 1; bkp_rst_n = 1;
    tick();

    // R1 / R2: sweep all 32 indices
    for (int i = 0; i < 32; i++) wr(i, pat(i, 1));
    read_all("R1/R2");
    for (int i = NW; i < 32; i++) wr(i, 32'hDEADBEEF);
    read_all("R2");

    // R4: system reset keeps words, ignores writes
    sys_rst_n = 0; wr_en = 1; addr = 0; wdata = 32'hFFFF_FFFF;
    repeat (3) tick();
    wr_en = 0; sys_rst_n = 1;
    tick();
    read_all("R4");
    check("R4 flag", 32'(tamp_flag), 0);

    // R6: detection disabled
    tamp_en = 0; tamper_in = 1;
    repeat (5) tick();
    tamper_in = 0;
    repeat (5) tick();
    check("R6 flag", 32'(tamp_flag), 0);
    read_all("R6");

    // R5 / R9 / R10: edge mode timing
    tamp_en = 1; tamp_level = 0; irq_en = 0;
    tamper_in = 1;                 // before edge N
    tick();                        // after N
    check("R5 flag N", 32'(tamp_flag), 0);
    tick();                        // after N+1
    check("R5 flag N+1", 32'(tamp_flag), 0);
    addr = 0; #1;
    check("R5 word N+1", rdata, model[0]);
    tick();                        // after N+2
    zero_model();
    check("R10 flag set", 32'(tamp_flag), 1);
    check("R11 irq off", 32'(tamp_irq), 0);
    read_all("R9");
    irq_en = 1; #1;
    check("R11 irq on", 32'(tamp_irq), 1);
    irq_en = 0; #1;
    check("R11 irq masked", 32'(tamp_irq), 0);

    // R7: held high gives no second event
    fill(2);
    repeat (4) tick();
    read_all("R7");
    flag_clr = 1; tick(); flag_clr = 0;
    check("R10 clear", 32'(tamp_flag), 0);
    repeat (4) tick();
    check("R7 no re-event", 32'(tamp_flag), 0);
    tamper_in = 0;
    repeat (4) tick();

    // R12: write collides with erase
    fill(3);
    tamper_in = 1;                 // before N
    tick(); tick();                // now before N+2
    wr_en = 1; addr = 3; wdata = 32'h1234_5678;
    tick();
    wr_en = 0;
    zero_model();
    addr = 3; #1;
    check("R12", rdata, 32'h0);
    read_all("R9");
    repeat (10) tick();
    check("R10 sticky", 32'(tamp_flag), 1);
    tamper_in = 0;
    flag_clr = 1; tick(); flag_clr = 0;
    repeat (4) tick();

    // R8: level mode
    tamp_level = 1;
    fill(4);
    tamper_in = 1;
    repeat (4) tick();
    zero_model();
    read_all("R8");
    flag_clr = 1; tick(); flag_clr = 0;
    check("R10 set wins", 32'(tamp_flag), 1);
    wr_en = 1; addr = 5; wdata = 32'hCAFE_F00D;
    tick(); wr_en = 0;
    addr = 5; #1;
    check("R8 held erase", rdata, 32'h0);
    tamper_in = 0;
    repeat (4) tick();
    flag_clr = 1; tick(); flag_clr = 0;
    check("R8 flag after release", 32'(tamp_flag), 0);
    wr(5, 32'hCAFE_F00D);
    read_all("R8 release");

    // R3: backup reset mid-run
    fill(5);
    bkp_rst_n = 0; tick(); bkp_rst_n = 1; tick();
    zero_model();
    read_all("R3 bkp");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule